// File: doc/BRIEF.md
# Fast Custom Interrupt CSR Unit

This unit gives a small RISC-V style core a bank of 32 extra machine-level interrupt lines, separate from the standard ones. It keeps its own enable mask and its own trap-vector base in custom control/status registers, and it offers a read-only view of the lines that are pending. The registers are reached through a simple single-cycle CSR port. The global machine interrupt enable gates every request. When more than one line is active, the lowest-numbered one wins. The unit then presents the winner's index and its vectored handler address to the core.

A two-state handshake machine models the core's side. In state HS_IDLE the unit raises its take request whenever a gated line is active. HS_IDLE moves to HS_BUSY in the cycle the core asserts accept while a request is present. In that same cycle the unit sends a one-cycle acknowledge, with the interrupt ID, to an external platform interrupt controller. HS_BUSY moves back to HS_IDLE in the cycle the core signals done. While in HS_BUSY, no request and no acknowledge are issued.

The enable mask comes out of reset as all ones, so every line is live without any software setup. The vector base resets to a parameter value, in the same way as the standard trap-vector register.

Top module: `fastirq_csr_unit`

## Requirements
- R1: After reset, the enable register (selector 0) reads all ones. The vector base register (selector 2) reads VEC_BASE_RESET with bits [1:0] shown as 2'b01. take_req_o and ack_o are low.
- R2: A CSR access (csr_req_i=1, csr_we_i=1) to selector 0 stores all 32 bits of csr_wdata_i into the enable mask from the next cycle. With csr_req_i=0, or csr_we_i=0, nothing is stored.
- R3: Selector 1 reads the current value of irq_lines_i. A write to selector 1 changes neither the enable mask nor the vector base.
- R4: A write to selector 2 stores csr_wdata_i[31:2] as the vector base. Bits [1:0] always read as 2'b01, whatever value was written.
- R5: In HS_IDLE, take_req_o is high exactly when mie_global_i is 1 and (irq_lines_i AND enable mask) is nonzero.
- R6: Among the active gated lines, the lowest-numbered one is chosen, and take_id_o carries its 5-bit index.
- R7: take_vec_o equals the base with bits [1:0] cleared, plus 4 times take_id_o.
- R8: ack_o is high for exactly the cycles in which take_req_o and accept_i are both high. In those cycles ack_id_o equals take_id_o.
- R9: After an acceptance the unit is in HS_BUSY. take_req_o and ack_o stay low until the cycle after done_i is seen high. done_i has no effect in HS_IDLE.
- R10: Selector 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_req_i | input | 1 | CSR access valid this cycle |
| csr_we_i | input | 1 | CSR access is a write |
| csr_sel_i | input | 2 | Register selector: 0 enable, 1 pending, 2 vector base, 3 none |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| irq_lines_i | input | 32 | Level-sensitive fast interrupt lines |
| mie_global_i | input | 1 | Global machine interrupt enable |
| accept_i | input | 1 | Core accepts the offered interrupt |
| done_i | input | 1 | Core has finished trap entry |
| take_req_o | output | 1 | Interrupt request to the core |
| take_id_o | output | 5 | Index of the selected line |
| take_vec_o | output | 32 | Vectored handler address |
| ack_o | output | 1 | One-cycle acknowledge to the external controller |
| ack_id_o | output | 5 | ID sent with the acknowledge |

## Verification
The assertions assume that every input holds a known value at each rising edge. They also assume that irq_lines_i and mie_global_i stay stable between the sampling edge and the combinational outputs they feed, since requests and acknowledges are derived from these inputs within the same cycle. The bench meets both conditions by driving all inputs once per cycle on the falling edge. It keeps accept_i and done_i as free random levels, so that done_i also lands in HS_IDLE and accept_i also arrives with no request pending, and both must then be ignored. Line patterns are thinned by ANDing several random words, which produces cycles with no active line, cycles with one active line and cycles with many.

// File: rtl/fastirq_pkg.sv
package fastirq_pkg;

    typedef enum logic [1:0] {
        CSEL_ENABLE  = 2'd0,
        CSEL_PENDING = 2'd1,
        CSEL_VBASE   = 2'd2,
        CSEL_NONE    = 2'd3
    } csr_sel_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_BUSY = 1'b1
    } hs_state_e;

    localparam logic [1:0] VEC_MODE_BITS = 2'b01;

endpackage

// File: rtl/fastirq_csr_bank.sv
module fastirq_csr_bank #(
    parameter int          NUM_LINES      = 32,
    parameter int          XLEN           = 32,
    parameter logic [31:0] VEC_BASE_RESET = 32'h0000_0080
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 csr_req_i,
    input  logic                 csr_we_i,
    input  logic [1:0]           csr_sel_i,
    input  logic [XLEN-1:0]      csr_wdata_i,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    output logic [XLEN-1:0]      csr_rdata_o,
    output logic [NUM_LINES-1:0] enable_o,
    output logic [XLEN-1:0]      base_o
);
    import fastirq_pkg::*;

    localparam int BASE_W = XLEN - 2;

    logic [NUM_LINES-1:0] en_q;
    logic [BASE_W-1:0]    base_q;
    logic                 wr_en;
    csr_sel_e             sel;

    assign sel   = csr_sel_e'(csr_sel_i);
    assign wr_en = csr_req_i && csr_we_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= '1;
            base_q <= VEC_BASE_RESET[XLEN-1:2];
        end else if (wr_en) begin
            if (sel == CSEL_ENABLE) en_q   <= csr_wdata_i[NUM_LINES-1:0];
            if (sel == CSEL_VBASE)  base_q <= csr_wdata_i[XLEN-1:2];
        end
    end

    always_comb begin
        csr_rdata_o = '0;
        unique case (sel)
            CSEL_ENABLE:  csr_rdata_o[NUM_LINES-1:0] = en_q;
            CSEL_PENDING: csr_rdata_o[NUM_LINES-1:0] = irq_lines_i;
            CSEL_VBASE:   csr_rdata_o = {base_q, VEC_MODE_BITS};
            CSEL_NONE:    csr_rdata_o = '0;
        endcase
    end

    assign enable_o = en_q;
    assign base_o   = {base_q, 2'b00};

endmodule

// File: rtl/fastirq_arbiter.sv
module fastirq_arbiter #(
    parameter int NUM_LINES = 32,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] active_i,
    output logic                 any_o,
    output logic [ID_W-1:0]      id_o
);
    logic [NUM_LINES-1:0] grant;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : gen_grant
            if (g == 0) begin : gen_first
                assign grant[g] = active_i[g];
            end else begin : gen_rest
                assign grant[g] = active_i[g] && !(|active_i[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        id_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (grant[i]) id_o = id_o | ID_W'(i);
        end
    end

    assign any_o = |active_i;

endmodule

// File: rtl/fastirq_handshake.sv
module fastirq_handshake (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cand_i,
    input  logic accept_i,
    input  logic done_i,
    output logic take_req_o,
    output logic ack_o
);
    import fastirq_pkg::*;

    hs_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= HS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        take_req_o = 1'b0;
        ack_o      = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                take_req_o = cand_i;
                if (cand_i && accept_i) begin
                    ack_o   = 1'b1;
                    state_d = HS_BUSY;
                end
            end
            HS_BUSY: begin
                if (done_i) state_d = HS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/fastirq_csr_unit.sv
module fastirq_csr_unit #(
    parameter int          NUM_LINES      = 32,
    parameter int          XLEN           = 32,
    parameter logic [31:0] VEC_BASE_RESET = 32'h0000_0080,
    localparam int         ID_W           = $clog2(NUM_LINES)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 csr_req_i,
    input  logic                 csr_we_i,
    input  logic [1:0]           csr_sel_i,
    input  logic [XLEN-1:0]      csr_wdata_i,
    output logic [XLEN-1:0]      csr_rdata_o,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 mie_global_i,
    input  logic                 accept_i,
    input  logic                 done_i,
    output logic                 take_req_o,
    output logic [ID_W-1:0]      take_id_o,
    output logic [XLEN-1:0]      take_vec_o,
    output logic                 ack_o,
    output logic [ID_W-1:0]      ack_id_o
);
    logic [NUM_LINES-1:0] enable;
    logic [XLEN-1:0]      base;
    logic                 any_active;
    logic [ID_W-1:0]      win_id;

    fastirq_csr_bank #(
        .NUM_LINES     (NUM_LINES),
        .XLEN          (XLEN),
        .VEC_BASE_RESET(VEC_BASE_RESET)
    ) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .csr_req_i  (csr_req_i),
        .csr_we_i   (csr_we_i),
        .csr_sel_i  (csr_sel_i),
        .csr_wdata_i(csr_wdata_i),
        .irq_lines_i(irq_lines_i),
        .csr_rdata_o(csr_rdata_o),
        .enable_o   (enable),
        .base_o     (base)
    );

    fastirq_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
        .active_i(irq_lines_i & enable),
        .any_o   (any_active),
        .id_o    (win_id)
    );

    fastirq_handshake u_hs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cand_i    (mie_global_i && any_active),
        .accept_i  (accept_i),
        .done_i    (done_i),
        .take_req_o(take_req_o),
        .ack_o     (ack_o)
    );

    assign take_id_o  = win_id;
    assign take_vec_o = base + (XLEN'(win_id) << 2);
    assign ack_id_o   = win_id;

endmodule

// File: rtl/fastirq_checks.sv
module fastirq_checks #(
    parameter int NUM_LINES = 32,
    parameter int XLEN      = 32,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_LINES-1:0] irq_lines_i,
    input logic                 mie_global_i,
    input logic                 accept_i,
    input logic                 take_req_o,
    input logic [ID_W-1:0]      take_id_o,
    input logic [XLEN-1:0]      take_vec_o,
    input logic                 ack_o,
    input logic [ID_W-1:0]      ack_id_o
);
    assert_ack_needs_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (take_req_o && accept_i));

    assert_ack_id_matches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (ack_id_o == take_id_o));

    assert_accept_acks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_req_o && accept_i) |-> ack_o);

    assert_no_back_to_back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> (!ack_o && !take_req_o));

    assert_req_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_req_o |-> (mie_global_i && (irq_lines_i != '0)));

    assert_winner_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_req_o |-> irq_lines_i[take_id_o]);

    assert_vec_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_req_o |-> (take_vec_o[1:0] == 2'b00));

endmodule

bind fastirq_csr_unit fastirq_checks #(.NUM_LINES(NUM_LINES), .XLEN(XLEN)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_lines_i (irq_lines_i),
    .mie_global_i(mie_global_i),
    .accept_i    (accept_i),
    .take_req_o  (take_req_o),
    .take_id_o   (take_id_o),
    .take_vec_o  (take_vec_o),
    .ack_o       (ack_o),
    .ack_id_o    (ack_id_o)
);

// File: tb/fastirq_csr_unit_tb.sv
module fastirq_csr_unit_tb_top;

    localparam logic [31:0] BASE_RST = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0, csr_we = 1'b0;
    logic [1:0]  csr_sel = 2'd3;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] lines = '0;
    logic        mie = 1'b0, accept = 1'b0, done = 1'b0;
    logic        take_req, ack;
    logic [4:0]  take_id, ack_id;
    logic [31:0] take_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] en_m;
    logic [29:0] base_m;
    bit          busy_m;

    always #2 clk = ~clk;

    fastirq_csr_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .csr_req_i(csr_req), .csr_we_i(csr_we), .csr_sel_i(csr_sel),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .irq_lines_i(lines), .mie_global_i(mie),
        .accept_i(accept), .done_i(done),
        .take_req_o(take_req), .take_id_o(take_id), .take_vec_o(take_vec),
        .ack_o(ack), .ack_id_o(ack_id)
    );

    function automatic logic [4:0] low_idx(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) low_idx = 5'(i);
        if (v == 0) low_idx = 5'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] s);
        case (s)
            2'd0: exp_read = en_m;
            2'd1: exp_read = lines;
            2'd2: exp_read = {base_m, 2'b01};
            default: exp_read = 32'h0;
        endcase
    endfunction

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, check 1 ns later, then mirror the coming edge in the model
    task automatic step(input logic rq, input logic we, input logic [1:0] sel,
                        input logic [31:0] wd, input logic [31:0] ln,
                        input logic m, input logic acc, input logic dn);
        logic [31:0] act_m;
        logic        req_e;
        @(negedge clk);
        csr_req = rq; csr_we = we; csr_sel = sel; csr_wdata = wd;
        lines = ln; mie = m; accept = acc; done = dn;
        #1;
        act_m = ln & en_m;
        req_e = !busy_m && m && (act_m != 0);
        cmp("R5 take_req", 32'(take_req), 32'(req_e));
        if (req_e) begin
            cmp("R6 take_id", 32'(take_id), 32'(low_idx(act_m)));
            cmp("R7 take_vec", take_vec, {base_m, 2'b00} + 32'(low_idx(act_m)) * 4);
        end
        cmp(busy_m ? "R9 ack while busy" : "R8 ack", 32'(ack), 32'(req_e && acc));
        if (req_e && acc) cmp("R8 ack_id", 32'(ack_id), 32'(low_idx(act_m)));
        if (sel == 2'd3) cmp("R10 read none", csr_rdata, 32'h0);
        else if (sel == 2'd1) cmp("R3 read pending", csr_rdata, exp_read(sel));
        else if (sel == 2'd2) cmp("R4 read base", csr_rdata, exp_read(sel));
        else cmp("R2 read enable", csr_rdata, exp_read(sel));
        if (rq && we && sel == 2'd0) en_m = wd;
        if (rq && we && sel == 2'd2) base_m = wd[31:2];
        if (busy_m && dn) busy_m = 1'b0;
        else if (req_e && acc) busy_m = 1'b1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        en_m = '1; base_m = BASE_RST[31:2]; busy_m = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        cmp("R1 reset take_req", 32'(take_req), 32'h0);
        cmp("R1 reset ack", 32'(ack), 32'h0);
        rst_n = 1'b1;
        // R1: reset values
        step(1, 0, 2'd0, 0, 0, 0, 0, 0);
        cmp("R1 reset enable", csr_rdata, 32'hFFFF_FFFF);
        step(1, 0, 2'd2, 0, 0, 0, 0, 0);
        cmp("R1 reset base", csr_rdata, BASE_RST | 32'h1);
        // R6/R7: lowest wins, highest line alone
        step(0, 0, 2'd1, 0, 32'h8000_0010, 1, 0, 0);
        cmp("R6 lowest of two", 32'(take_id), 32'd4);
        step(0, 0, 2'd1, 0, 32'h8000_0000, 1, 0, 0);
        cmp("R7 line31 vector", take_vec, BASE_RST + 32'd124);
        // R5: global enable low blocks
        step(0, 0, 2'd3, 0, 32'hFFFF_FFFF, 0, 1, 0);
        // R4: base write with low bits set
        step(1, 1, 2'd2, 32'h0000_1003, 0, 0, 0, 0);
        step(1, 0, 2'd2, 0, 32'h0000_0004, 1, 0, 0);
        cmp("R4 base low bits", csr_rdata, 32'h0000_1001);
        cmp("R7 vector new base", take_vec, 32'h0000_1008);
        // R3 / R10: writes to pending and none ignored
        step(1, 1, 2'd1, 32'h0, 0, 0, 0, 0);
        step(1, 1, 2'd3, 32'h0, 0, 0, 0, 0);
        step(1, 0, 2'd0, 0, 0, 0, 0, 0);
        cmp("R3 pending write ignored", csr_rdata, 32'hFFFF_FFFF);
        // R2: write without req ignored, then real write masks
        step(0, 1, 2'd0, 32'h0, 0, 0, 0, 0);
        step(1, 1, 2'd0, 32'h0000_FF00, 0, 0, 0, 0);
        step(0, 0, 2'd0, 0, 32'h0000_00FF, 1, 0, 0);
        cmp("R2 masked lines no req", 32'(take_req), 32'h0);
        // R8/R9: accept then busy until done
        step(0, 0, 2'd3, 0, 32'h0000_0300, 1, 1, 0);
        cmp("R8 ack pulse", 32'(ack), 32'h1);
        step(0, 0, 2'd3, 0, 32'h0000_0300, 1, 1, 0);
        cmp("R9 busy no req", 32'(take_req), 32'h0);
        step(0, 0, 2'd3, 0, 32'h0000_0300, 1, 1, 1);
        step(0, 0, 2'd3, 0, 32'h0000_0300, 1, 0, 0);
        cmp("R9 idle after done", 32'(take_req), 32'h1);
        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] s;
            s = 2'($urandom);
            step(($urandom % 4) == 0, ($urandom % 3) == 0, s, $urandom,
                 $urandom & $urandom & $urandom, ($urandom % 5) != 0,
                 ($urandom % 2) == 0, ($urandom % 3) == 0);
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule